// File: doc/BRIEF.md
# Security-Aware Interrupt Priority Register File

This block stores one 8-bit priority for every shared interrupt and presents the whole set to a downstream arbiter as a flat vector. Software reaches the priorities through a small request/response register bus. Byte address k names the priority of interrupt k, and a 32-bit access covers four neighbouring interrupts. Every request carries a secure attribute. The group membership of each interrupt is supplied from outside as an input vector. A global input turns the security checks off.

A secure request, or any request made while security is disabled, sees the raw stored byte. A non-secure request with security enabled has two restrictions. It can reach only interrupts whose group bit marks them non-secure. It also sees a view of the priority shifted by one bit. On a write, the top bit of the stored value is forced to one, so that non-secure software can only place interrupts in the lower-priority half of the range. Fields outside the shared range (below 32, or at or above the implemented count) always read zero and ignore writes. Half-word accesses are treated as no-ops.

The request side is valid/ready. Each accepted request produces exactly one response beat on a valid/ready response channel. The response slot holds one beat. While a response waits with `rsp_ready` low, no new request is accepted, so back-pressure reaches the requester in the same cycle.

Top module: `prio_regfile_sec`

## Requirements
- R1: After reset every priority field on `prio_out` is zero, `upd_mask` is zero and `rsp_valid` is low.
- R2: The `req_size` input selects the access size: 0 selects a byte, 1 a half-word, 2 a 32-bit word, and 3 is reserved. A byte access addresses interrupt `req_addr`, and its data sits in bits 7:0 of the write and read data, with the read data's upper bits zero. A word access ignores `req_addr[1:0]` and uses the aligned base b. Byte lane i, at bits 8i+7:8i, belongs to interrupt b+i.
- R3: For a secure request, or for any request while `sec_disable` is 1, a read returns the stored byte and a write stores the written byte unchanged.
- R4: Security is enabled when `sec_disable` is 0. With security enabled, a non-secure read of an interrupt whose `group_ns` bit is 1 returns the stored value shifted left by one, truncated to 8 bits.
- R5: With security enabled, a non-secure write to an interrupt whose `group_ns` bit is 1 stores 0x80 OR the written byte shifted right by one.
- R6: With security enabled, a non-secure request to an interrupt whose `group_ns` bit is 0 reads zero in that lane and leaves that field unchanged. Other lanes of the same word are still served.
- R7: A field for an interrupt below 32, or at or above NUM_IRQ, reads zero and is never written.
- R8: A word write is dropped in all four lanes if any of its four interrupts is below 32 or at or above NUM_IRQ.
- R9: A half-word or reserved-size request reads zero and writes nothing.
- R10: A write accepted at a clock edge shows on `prio_out` just after that edge. In that same cycle `upd_mask` carries a one-cycle pulse for each field that was written and zero for every other field.
- R11: Each accepted request yields one response, with `rsp_valid` high from the next edge. Read data reflects the state before the request, and a write responds with zero data. The response holds with stable data while `rsp_ready` is low. `req_ready` is high exactly when the slot is empty or is being drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle when valid is also high |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2 word, 3 reserved |
| req_addr | input | ADDR_W | Byte address (interrupt number) |
| req_wdata | input | 32 | Write data |
| req_secure | input | 1 | Secure attribute of the request |
| sec_disable | input | 1 | 1 = security checks disabled |
| group_ns | input | NUM_IRQ | Per-interrupt group bit, 1 = non-secure group |
| rsp_valid | output | 1 | Response beat present |
| rsp_rdata | output | 32 | Response read data |
| rsp_ready | input | 1 | Requester takes the response |
| prio_out | output | NUM_IRQ*8 | Priority of interrupt k at bits 8k+7:8k |
| upd_mask | output | NUM_IRQ | One-cycle pulse per field just written |

## Verification
The block has one register stage between the request and every one of its results. A request accepted at a rising edge updates `prio_out` and pulses `upd_mask` just after that edge, and its response beat becomes valid at that same edge. The response then holds for as many cycles as `rsp_ready` stays low. The bench changes its inputs just after rising edges. Its behavioural model samples those inputs at the following falling edge and advances one step per clock. At that falling edge it first compares every output with the state predicted for the edge just past, and then predicts the next one. No check depends on edge ordering.

// File: rtl/prio_regfile_pkg.sv
package prio_regfile_pkg;
  localparam int PRIO_W = 8;
  localparam int BUS_W  = 32;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  // Restricted-view read: shift toward the top, drop the old top bit.
  function automatic logic [PRIO_W-1:0] restricted_rd(input logic [PRIO_W-1:0] raw);
    return {raw[PRIO_W-2:0], 1'b0};
  endfunction

  // Restricted-view write: halve and force into the lower-priority half.
  function automatic logic [PRIO_W-1:0] restricted_wr(input logic [PRIO_W-1:0] wv);
    return {1'b1, wv[PRIO_W-1:1]};
  endfunction
endpackage

// File: rtl/prio_lane_gate.sv
module prio_lane_gate
  import prio_regfile_pkg::*;
#(
  parameter int NUM_IRQ      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int ADDR_W       = 10
) (
  input  logic [ADDR_W-1:0] lane_irq,
  input  logic [PRIO_W-1:0] lane_raw,
  input  logic              lane_grp_ns,
  input  logic              restricted,
  input  logic [PRIO_W-1:0] lane_wbyte,
  output logic              in_range,
  output logic              allowed,
  output logic [PRIO_W-1:0] rd_view,
  output logic [PRIO_W-1:0] wr_value
);
  always_comb begin
    in_range = (32'(lane_irq) >= 32'(FIRST_SHARED)) && (32'(lane_irq) < 32'(NUM_IRQ));
    allowed  = in_range && (!restricted || lane_grp_ns);
    rd_view  = restricted ? restricted_rd(lane_raw)   : lane_raw;
    wr_value = restricted ? restricted_wr(lane_wbyte) : lane_wbyte;
  end
endmodule

// File: rtl/prio_bank.sv
module prio_bank
  import prio_regfile_pkg::*;
#(
  parameter int NUM_IRQ      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int LANES        = 4,
  parameter int IDX_W        = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANES-1:0]  lane_we,
  input  logic [IDX_W-1:0]  lane_idx  [LANES],
  input  logic [PRIO_W-1:0] lane_wval [LANES],
  output logic [PRIO_W-1:0] prio_arr  [NUM_IRQ],
  output logic [NUM_IRQ-1:0] upd_mask
);
  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_fld
    if (j < FIRST_SHARED) begin : g_fixed
      assign prio_arr[j] = '0;
      assign upd_mask[j] = 1'b0;
    end else begin : g_reg
      logic              fld_we;
      logic [PRIO_W-1:0] fld_wv;
      logic [PRIO_W-1:0] fld_q;
      logic              upd_q;

      always_comb begin
        fld_we = 1'b0;
        fld_wv = '0;
        for (int l = 0; l < LANES; l++) begin
          if (lane_we[l] && (lane_idx[l] == IDX_W'(j))) begin
            fld_we = 1'b1;
            fld_wv = lane_wval[l];
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          fld_q <= '0;
          upd_q <= 1'b0;
        end else begin
          upd_q <= fld_we;
          if (fld_we) fld_q <= fld_wv;
        end
      end

      assign prio_arr[j] = fld_q;
      assign upd_mask[j] = upd_q;
    end
  end
endmodule

// File: rtl/prio_rsp_slot.sv
module prio_rsp_slot #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              rsp_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              slot_free
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (load) begin
      rsp_valid <= 1'b1;
      rsp_data  <= load_data;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assign slot_free = !rsp_valid || rsp_ready;
endmodule

// File: rtl/prio_regfile_sec.sv
module prio_regfile_sec
  import prio_regfile_pkg::*;
#(
  parameter int NUM_IRQ      = 64,
  parameter int FIRST_SHARED = 32,
  parameter int ADDR_W       = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [1:0]               req_size,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [BUS_W-1:0]         req_wdata,
  input  logic                     req_secure,
  input  logic                     sec_disable,
  input  logic [NUM_IRQ-1:0]       group_ns,
  output logic                     rsp_valid,
  output logic [BUS_W-1:0]         rsp_rdata,
  input  logic                     rsp_ready,
  output logic [NUM_IRQ*PRIO_W-1:0] prio_out,
  output logic [NUM_IRQ-1:0]       upd_mask
);
  localparam int LANES = BUS_W / PRIO_W;
  localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  acc_size_e         sz;
  logic              is_byte, is_word;
  logic              accept, restricted, word_ok;
  logic [ADDR_W-1:0] addr_base;
  logic [BUS_W-1:0]  rd_lanes, rsp_load_data;
  logic              slot_free;

  logic [PRIO_W-1:0] prio_arr  [NUM_IRQ];
  logic [IDX_W-1:0]  lane_idx  [LANES];
  logic [PRIO_W-1:0] lane_wval [LANES];
  logic [LANES-1:0]  lane_we, lane_act, lane_inr, lane_ok;

  assign sz         = acc_size_e'(req_size);
  assign is_byte    = (sz == SZ_BYTE);
  assign is_word    = (sz == SZ_WORD);
  assign restricted = !req_secure && !sec_disable;
  assign req_ready  = slot_free;
  assign accept     = req_valid && req_ready;
  assign addr_base  = is_word ? {req_addr[ADDR_W-1:2], 2'b00} : req_addr;
  assign word_ok    = &lane_inr;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [ADDR_W-1:0] lane_irq;
    logic [PRIO_W-1:0] lane_raw, lane_wbyte, rd_view;
    logic              lane_grp;

    assign lane_irq = addr_base + ADDR_W'(l);
    assign lane_idx[l] = lane_irq[IDX_W-1:0];

    if (l == 0) begin : g_first
      assign lane_act[l] = is_word || is_byte;
      assign lane_wbyte  = req_wdata[PRIO_W-1:0];
    end else begin : g_rest
      assign lane_act[l] = is_word;
      assign lane_wbyte  = req_wdata[l*PRIO_W +: PRIO_W];
    end

    always_comb begin
      lane_raw = '0;
      lane_grp = 1'b0;
      if (lane_inr[l]) begin
        lane_raw = prio_arr[lane_idx[l]];
        lane_grp = group_ns[lane_idx[l]];
      end
    end

    prio_lane_gate #(
      .NUM_IRQ     (NUM_IRQ),
      .FIRST_SHARED(FIRST_SHARED),
      .ADDR_W      (ADDR_W)
    ) u_gate (
      .lane_irq   (lane_irq),
      .lane_raw   (lane_raw),
      .lane_grp_ns(lane_grp),
      .restricted (restricted),
      .lane_wbyte (lane_wbyte),
      .in_range   (lane_inr[l]),
      .allowed    (lane_ok[l]),
      .rd_view    (rd_view),
      .wr_value   (lane_wval[l])
    );

    assign rd_lanes[l*PRIO_W +: PRIO_W] = (lane_act[l] && lane_ok[l]) ? rd_view : '0;
    assign lane_we[l] = accept && req_write && lane_act[l] && lane_ok[l]
                        && (!is_word || word_ok);
  end

  assign rsp_load_data = req_write ? '0 : rd_lanes;

  prio_bank #(
    .NUM_IRQ     (NUM_IRQ),
    .FIRST_SHARED(FIRST_SHARED),
    .LANES       (LANES),
    .IDX_W       (IDX_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .lane_we  (lane_we),
    .lane_idx (lane_idx),
    .lane_wval(lane_wval),
    .prio_arr (prio_arr),
    .upd_mask (upd_mask)
  );

  prio_rsp_slot #(
    .DATA_W(BUS_W)
  ) u_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (accept),
    .load_data(rsp_load_data),
    .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid),
    .rsp_data (rsp_rdata),
    .slot_free(slot_free)
  );

  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_flat
    assign prio_out[j*PRIO_W +: PRIO_W] = prio_arr[j];
  end
endmodule

// File: rtl/prio_regfile_sec_chk.sv
module prio_regfile_sec_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   req_valid,
  input logic                   req_ready,
  input logic                   req_write,
  input logic [1:0]             req_size,
  input logic                   req_secure,
  input logic                   sec_disable,
  input logic                   rsp_valid,
  input logic                   rsp_ready,
  input logic [31:0]            rsp_rdata,
  input logic [NUM_IRQ*8-1:0]   prio_out,
  input logic [NUM_IRQ-1:0]     upd_mask
);
  logic                 started;
  logic                 acc_wr;
  logic                 top_ok;
  logic [NUM_IRQ*8-1:0] keep_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) started <= 1'b0;
    else        started <= 1'b1;
  end

  assign acc_wr = req_valid && req_ready && req_write;

  always_comb begin
    top_ok = 1'b1;
    for (int j = 0; j < NUM_IRQ; j++) begin
      keep_bits[j*8 +: 8] = {8{~upd_mask[j]}};
      if (upd_mask[j] && !prio_out[j*8+7]) top_ok = 1'b0;
    end
  end

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_rdata)); // R11

  AST_RSP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid); // R11

  AST_UPD_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    started && (upd_mask != '0) |-> $past(acc_wr)); // R10

  AST_FIELD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    started |-> ((prio_out ^ $past(prio_out)) & keep_bits) == '0); // R10

  AST_HALF_NO_UPD: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc_wr && (req_size == 2'd1 || req_size == 2'd3)) |-> upd_mask == '0); // R9

  AST_NS_TOP_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc_wr && !req_secure && !sec_disable) |-> top_ok); // R5

  AST_BYTE_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    started && $past(acc_wr && req_size == 2'd0) |-> $onehot0(upd_mask)); // R2

  AST_WORD_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(upd_mask) <= 4); // R8
endmodule

bind prio_regfile_sec prio_regfile_sec_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_write  (req_write),
  .req_size   (req_size),
  .req_secure (req_secure),
  .sec_disable(sec_disable),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_rdata  (rsp_rdata),
  .prio_out   (prio_out),
  .upd_mask   (upd_mask)
);

// File: tb/prio_regfile_sec_bench.sv
module prio_regfile_sec_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NUM        = 64;
  localparam int AW         = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic              req_write = 1'b0;
  logic [1:0]        req_size = 2'd0;
  logic [AW-1:0]     req_addr = '0;
  logic [31:0]       req_wdata = '0;
  logic              req_secure = 1'b1;
  logic              sec_disable = 1'b0;
  logic [NUM-1:0]    group_ns;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              rsp_ready = 1'b1;
  logic [NUM*8-1:0]  prio_out;
  logic [NUM-1:0]    upd_mask;

  int     checks = 0;
  int     errors = 0;
  bit     finished = 0;
  string  cur_tag = "R1";

  int           m_prio [NUM];
  logic [NUM-1:0] m_upd;
  bit           m_rv;
  logic [31:0]  m_rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Odd-numbered interrupts belong to the non-secure group.
  for (genvar g = 0; g < NUM; g++) begin : g_grp
    assign group_ns[g] = (g % 2) == 1;
  end

  prio_regfile_sec #(.NUM_IRQ(NUM), .FIRST_SHARED(32), .ADDR_W(AW)) u_prio_regfile_sec (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_secure(req_secure), .sec_disable(sec_disable),
    .group_ns(group_ns), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_ready(rsp_ready), .prio_out(prio_out), .upd_mask(upd_mask)
  );

  task automatic chk(input string tag, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int lane_rd(input int irq);
    bit r;
    r = !req_secure && !sec_disable;
    if (irq < 32 || irq >= NUM) return 0;
    if (r && !group_ns[irq]) return 0;
    return r ? ((m_prio[irq] * 2) % 256) : m_prio[irq];
  endfunction

  function automatic void lane_wr(input int irq, input int wv);
    bit r;
    r = !req_secure && !sec_disable;
    if (irq < 32 || irq >= NUM) return;
    if (r && !group_ns[irq]) return;
    m_prio[irq] = r ? (128 + wv / 2) : wv;
    m_upd[irq]  = 1'b1;
  endfunction

  function automatic logic [31:0] model_access();
    logic [31:0] rd;
    int a, base;
    rd = '0;
    a  = int'(req_addr);
    if (req_size == 2'd0) begin
      rd[7:0] = 8'(lane_rd(a));
      if (req_write) lane_wr(a, int'(req_wdata[7:0]));
    end else if (req_size == 2'd2) begin
      base = a - (a % 4);
      for (int i = 0; i < 4; i++) rd[i*8 +: 8] = 8'(lane_rd(base + i));
      if (req_write && base >= 32 && base + 3 < NUM)
        for (int i = 0; i < 4; i++) lane_wr(base + i, int'(req_wdata[i*8 +: 8]));
    end
    return req_write ? 32'h0 : rd;
  endfunction

  always @(negedge clk) begin
    logic [31:0] rdv;
    bit acc;
    if (!rst_n) begin
      m_rv = 0; m_rd = '0; m_upd = '0;
      for (int j = 0; j < NUM; j++) m_prio[j] = 0;
    end else if (!finished) begin
      for (int j = 0; j < NUM; j++)
        chk({cur_tag, "/R10"}, $sformatf("prio[%0d]", j),
            64'(prio_out[j*8 +: 8]), 64'(m_prio[j]));
      chk({cur_tag, "/R10"}, "upd_mask", 64'(upd_mask), 64'(m_upd));
      chk({cur_tag, "/R11"}, "rsp_valid", 64'(rsp_valid), 64'(m_rv));
      if (m_rv) chk({cur_tag, "/R11"}, "rsp_rdata", 64'(rsp_rdata), 64'(m_rd));
      chk("R11", "req_ready", 64'(req_ready), 64'(!m_rv || rsp_ready));
      m_upd = '0;
      acc = req_valid && (!m_rv || rsp_ready);
      if (acc) begin
        rdv  = model_access();
        m_rv = 1;
        m_rd = rdv;
      end else if (m_rv && rsp_ready) begin
        m_rv = 0;
      end
    end
  end

  task automatic do_req(input bit wr, input logic [1:0] sz, input int addr,
                        input logic [31:0] wd, input bit sec);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr; req_size = sz;
    req_addr = AW'(addr); req_wdata = wd; req_secure = sec;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);           // R1 checks at each falling edge
    cur_tag = "R3";                      // secure raw byte write and read
    do_req(1, 2'd0, 40, 32'h5A, 1);
    do_req(0, 2'd0, 40, 0, 1);
    do_req(1, 2'd0, 41, 32'h63, 1);
    cur_tag = "R2";                      // word lane placement
    do_req(1, 2'd2, 44, 32'h44332211, 1);
    do_req(0, 2'd2, 46, 0, 1);
    do_req(0, 2'd0, 45, 0, 1);
    cur_tag = "R4";                      // restricted read view
    do_req(0, 2'd0, 41, 0, 0);
    do_req(0, 2'd2, 44, 0, 0);
    cur_tag = "R5";                      // restricted write forces top bit
    do_req(1, 2'd0, 43, 32'h40, 0);
    do_req(0, 2'd0, 43, 0, 1);
    do_req(1, 2'd0, 45, 32'hFF, 0);
    cur_tag = "R6";                      // secure-group field hidden
    do_req(0, 2'd0, 40, 0, 0);
    do_req(1, 2'd0, 40, 32'h11, 0);
    do_req(0, 2'd0, 40, 0, 1);
    do_req(1, 2'd2, 48, 32'h11223344, 0);
    do_req(0, 2'd2, 48, 0, 1);
    cur_tag = "R7";                      // outside the shared range
    do_req(1, 2'd0, 31, 32'h77, 1);
    do_req(0, 2'd0, 31, 0, 1);
    do_req(1, 2'd0, 64, 32'h77, 1);
    do_req(0, 2'd0, 64, 0, 1);
    do_req(0, 2'd0, 63, 0, 1);
    cur_tag = "R8";                      // whole-word drop
    do_req(1, 2'd2, 28, 32'hAABBCCDD, 1);
    do_req(1, 2'd2, 64, 32'hAABBCCDD, 1);
    do_req(1, 2'd2, 61, 32'hDEADBEEF, 1);
    do_req(0, 2'd2, 60, 0, 1);
    cur_tag = "R9";                      // half and reserved sizes
    do_req(1, 2'd1, 52, 32'hFFFF, 1);
    do_req(0, 2'd1, 44, 0, 1);
    do_req(1, 2'd3, 52, 32'hFFFFFFFF, 1);
    do_req(0, 2'd3, 44, 0, 1);
    cur_tag = "R3";                      // security disabled: raw view
    sec_disable = 1'b1;
    do_req(1, 2'd0, 40, 32'h12, 0);
    do_req(0, 2'd0, 41, 0, 0);
    sec_disable = 1'b0;
    cur_tag = "R11";                     // back-pressure on the response
    @(posedge clk); #1 rsp_ready = 1'b0;
    do_req(0, 2'd2, 44, 0, 1);
    fork
      do_req(1, 2'd0, 50, 32'h9C, 1);
      begin repeat (4) @(posedge clk); #2 rsp_ready = 1'b1; end
    join
    do_req(1, 2'd2, 52, 32'h01020304, 1);
    do_req(0, 2'd2, 52, 0, 1);
    cur_tag = "R10";
    repeat (4) @(posedge clk);
    @(negedge clk); #1;
    finish_run();
  end
endmodule